// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is a serial chain of scan cells that sits between the core's I/O signals and the device pins, one cell per signal. Each cell holds a shift stage and a separate update stage, and it has an output multiplexer that either passes its parallel input straight through or substitutes the held test value. A test-access controller outside the block drives three strobes: capture, shift and update. It also drives a two-bit mode select. Test data enters at `tdi` and leaves at `tdo`.

Each cell is built as one of two kinds. In an output-kind cell the parallel input comes from the core and the parallel output drives a pin. In an input-kind cell the parallel input comes from a pin and the parallel output feeds the core. The external-test mode replaces what the output-kind cells drive onto the pins with scan data. The internal-test mode replaces what the input-kind cells hand to the core. A bit mask parameter sets the kind of each cell. In all other modes the chain is transparent.

The serial order is fixed. `tdi` enters cell `CELLS-1` and each shift moves data one cell toward cell 0. The shift stage of cell 0 drives `tdo` directly. After a capture, `tdo` therefore presents `par_in[0]` first. After `CELLS` shifts, the bit that was shifted in k-th (counting from 0) sits in cell k.

Top module: `bscan_chain`

## Requirements
- R1: When `mode` is 2'b00 (functional) or 2'b11 (reserved, treated as functional), `par_out` equals `par_in` combinationally for every cell.
- R2: A rising `clk` edge with `cap_en` high loads every shift stage from its own `par_in` bit in parallel.
- R3: `tdo` always shows the shift stage of cell 0. A rising edge with `shf_en` high and `cap_en` low moves each stage one cell toward cell 0 and loads `tdi` into cell `CELLS-1`. A pattern shifted in therefore reappears on `tdo` `CELLS` shifts later, in the same order.
- R4: With `cap_en` and `shf_en` both low, the shift stages hold their value and `tdo` does not change.
- R5: The update stages change only on an edge with `upd_en` high, when they copy the shift stages. Shifting alone never alters `par_out`.
- R6: When `mode` is 2'b01 (external test), output-kind cells (bit set in `OUT_CELLS`) drive `par_out` from their update stage, and input-kind cells pass `par_in` through.
- R7: When `mode` is 2'b10 (internal test), input-kind cells drive `par_out` from their update stage, and output-kind cells pass `par_in` through.
- R8: When `cap_en` and `shf_en` are high on the same edge, the capture wins. When `upd_en` coincides with a shift or a capture, the update stage takes the shift-stage value from before that edge.
- R9: While `rst_n` is low, all shift and update stages are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all stages change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all stages |
| cap_en | input | 1 | Capture strobe: parallel load of shift stages |
| shf_en | input | 1 | Shift strobe: move chain one cell toward `tdo` |
| upd_en | input | 1 | Update strobe: copy shift stages to update stages |
| mode | input | 2 | 00 functional, 01 external test, 10 internal test, 11 functional |
| tdi | input | 1 | Serial data into cell `CELLS-1` |
| tdo | output | 1 | Serial data from cell 0 |
| par_in | input | CELLS | Parallel inputs (core side for output cells, pin side for input cells) |
| par_out | output | CELLS | Parallel outputs (pin side for output cells, core side for input cells) |

## Verification
Two pairs of functions can land on the same edge. Capture and shift can collide in the shift stage, and update and shift can collide between the two stages. The bench forces both collisions directly. It first asserts capture and shift together with a distinctive `par_in`, then asserts update together with a shift. It judges the result by reading the whole chain back through `tdo` and by watching `par_out` in external-test mode. That output must show the pre-shift value, not the shifted one. Random strobe mixes then hit the same collisions many more times, and a reference model in the bench checks every cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_INT  = 2'b10,
        MODE_RSVD = 2'b11
    } bsc_mode_e;

    typedef struct packed {
        logic stage;
        logic hold;
    } bsc_cell_t;

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic shf_en,
    input  logic upd_en,
    input  logic par_in,
    input  logic ser_in,
    output logic stage_o,
    output logic hold_o
);

    bsc_cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // capture has priority over shift on the same edge
        if (cap_en) begin
            st_d.stage = par_in;
        end else if (shf_en) begin
            st_d.stage = ser_in;
        end
        // update copies the pre-edge shift value
        if (upd_en) begin
            st_d.hold = st_q.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign hold_o  = st_q.hold;

endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
    import bscan_pkg::*;
#(
    parameter bit DRIVES_PIN = 1'b0
) (
    input  logic [1:0] mode,
    input  logic       par_in,
    input  logic       hold,
    output logic       par_out
);

    logic take_hold;

    generate
        if (DRIVES_PIN) begin : g_out_kind
            always_comb take_hold = (mode == MODE_EXT);
        end else begin : g_in_kind
            always_comb take_hold = (mode == MODE_INT);
        end
    endgenerate

    always_comb begin
        par_out = take_hold ? hold : par_in;
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int unsigned          CELLS     = 8,
    parameter logic [CELLS-1:0]     OUT_CELLS = {{(CELLS/2){1'b1}}, {(CELLS-CELLS/2){1'b0}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             shf_en,
    input  logic             upd_en,
    input  logic [1:0]       mode,
    input  logic             tdi,
    output logic             tdo,
    input  logic [CELLS-1:0] par_in,
    output logic [CELLS-1:0] par_out
);

    localparam int unsigned LAST = CELLS - 1;

    logic [CELLS-1:0] stage;
    logic [CELLS-1:0] hold;
    logic [CELLS-1:0] ser_link;

    // serial data enters the top cell and travels toward cell 0
    assign ser_link = {tdi, stage[LAST:1]};
    assign tdo      = stage[0];

    generate
        for (genvar g = 0; g < CELLS; g++) begin : g_cell
            bscan_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .cap_en  (cap_en),
                .shf_en  (shf_en),
                .upd_en  (upd_en),
                .par_in  (par_in[g]),
                .ser_in  (ser_link[g]),
                .stage_o (stage[g]),
                .hold_o  (hold[g])
            );

            bscan_pin_mux #(
                .DRIVES_PIN (OUT_CELLS[g])
            ) u_mux (
                .mode    (mode),
                .par_in  (par_in[g]),
                .hold    (hold[g]),
                .par_out (par_out[g])
            );
        end
    endgenerate

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int unsigned      CELLS     = 8,
    parameter logic [CELLS-1:0] OUT_CELLS = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             shf_en,
    input logic             upd_en,
    input logic [1:0]       mode,
    input logic             tdi,
    input logic             tdo,
    input logic [CELLS-1:0] par_in,
    input logic [CELLS-1:0] par_out,
    input logic [CELLS-1:0] stage,
    input logic [CELLS-1:0] hold
);

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cap_en |=> stage == $past(par_in)); // R2
    AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n) (shf_en && !cap_en) |=> tdo == $past(stage[1])); // R3
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n) (shf_en && !cap_en) |=> stage[CELLS-1] == $past(tdi)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!shf_en && !cap_en) |=> $stable(stage)); // R4
    AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n) upd_en |=> hold == $past(stage)); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !upd_en |=> $stable(hold)); // R5
    AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b00 || mode == 2'b11) |-> par_out == par_in); // R1
    AST_EXT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b01) |-> (((par_out ^ hold) & OUT_CELLS) == '0 && ((par_out ^ par_in) & ~OUT_CELLS) == '0)); // R6
    AST_INT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10) |-> (((par_out ^ hold) & ~OUT_CELLS) == '0 && ((par_out ^ par_in) & OUT_CELLS) == '0)); // R7
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (cap_en && shf_en) |=> stage == $past(par_in)); // R8

endmodule

bind bscan_chain bscan_chain_chk #(
    .CELLS     (CELLS),
    .OUT_CELLS (OUT_CELLS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .shf_en  (shf_en),
    .upd_en  (upd_en),
    .mode    (mode),
    .tdi     (tdi),
    .tdo     (tdo),
    .par_in  (par_in),
    .par_out (par_out),
    .stage   (stage),
    .hold    (hold)
);

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;

    localparam int unsigned N = 8;
    localparam logic [N-1:0] OUTM = 8'hF0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [N-1:0] par_in = '0;
    logic tdo;
    logic [N-1:0] par_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [N-1:0] m_stage = '0;
    logic [N-1:0] m_hold = '0;
    logic         last_tdo;
    logic [N-1:0] last_po;
    logic [N-1:0] got;

    always #2.5 clk = ~clk;

    bscan_chain #(.CELLS(N), .OUT_CELLS(OUTM)) i_bscan_chain (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en),
        .mode(mode), .tdi(tdi), .tdo(tdo), .par_in(par_in), .par_out(par_out)
    );

    function automatic logic [N-1:0] exp_out(input logic [1:0] md, input logic [N-1:0] pi,
                                             input logic [N-1:0] hd);
        if (md == 2'b01) return (hd & OUTM) | (pi & ~OUTM);
        if (md == 2'b10) return (hd & ~OUTM) | (pi & OUTM);
        return pi;
    endfunction

    function automatic string mode_req(input logic [1:0] md);
        if (md == 2'b01) return "R6";
        if (md == 2'b10) return "R7";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, check just after, model the edge
    task automatic cycle(input logic cap, input logic sh, input logic up, input logic sin,
                         input logic [1:0] md, input logic [N-1:0] pi);
        @(negedge clk);
        cap_en = cap; shf_en = sh; upd_en = up; tdi = sin; mode = md; par_in = pi;
        #1;
        last_tdo = tdo;
        last_po  = par_out;
        check("R3 tdo", 32'(tdo), 32'(m_stage[0]));
        check(mode_req(md), 32'(par_out), 32'(exp_out(md, pi, m_hold)));
        @(posedge clk);
        if (up) m_hold = m_stage;
        if (cap) m_stage = pi;
        else if (sh) m_stage = {sin, m_stage[N-1:1]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd1149);
        // R9: cleared state visible while in reset
        mode = 2'b01; par_in = 8'h5A;
        #7;
        check("R9 tdo", 32'(tdo), 32'd0);
        check("R9 ext out", 32'(par_out), 32'(8'h0A));
        mode = 2'b00;
        #1;
        check("R1 reset pass", 32'(par_out), 32'(8'h5A));
        @(negedge clk); rst_n = 1'b1;

        // R2: capture then read back through tdo, shifting in A5
        cycle(1, 0, 0, 0, 2'b00, 8'h3C);
        for (int k = 0; k < N; k++) begin
            logic [7:0] pat;
            pat = 8'hA5;
            cycle(0, 1, 0, pat[k], 2'b00, 8'($urandom));
            got[k] = last_tdo;
        end
        check("R2 capture readback", 32'(got), 32'(8'h3C));

        // R4/R5: stages hold while idle; pins unchanged before update
        cycle(0, 0, 0, 1, 2'b01, 8'h00);
        cycle(0, 0, 0, 0, 2'b01, 8'h00);
        check("R4 idle tdo", 32'(last_tdo), 32'd1);
        check("R5 no update yet", 32'(last_po), 32'(8'h00));
        cycle(0, 0, 1, 0, 2'b01, 8'h00);
        cycle(0, 0, 0, 0, 2'b01, 8'h03);
        check("R6 ext drive", 32'(last_po), 32'(8'hA3));
        cycle(0, 0, 0, 0, 2'b10, 8'hC0);
        check("R7 int drive", 32'(last_po), 32'(8'hC5));

        // R3: shift A5 back out unchanged
        for (int k = 0; k < N; k++) begin
            cycle(0, 1, 0, 0, 2'b00, 8'h00);
            got[k] = last_tdo;
        end
        check("R3 pattern out", 32'(got), 32'(8'hA5));

        // R8: capture with shift, then update with shift
        cycle(1, 1, 0, 1, 2'b00, 8'h96);
        cycle(0, 1, 1, 1, 2'b00, 8'h00);
        cycle(0, 0, 0, 0, 2'b01, 8'h00);
        check("R8 update pre-shift", 32'(last_po), 32'(8'h90));
        for (int k = 0; k < N; k++) begin
            cycle(0, 1, 0, 0, 2'b00, 8'h00);
            got[k] = last_tdo;
        end
        check("R8 capture wins", 32'(got), 32'(8'hCB));

        // random mix, checked every cycle against the model
        for (int i = 0; i < 600; i++) begin
            cycle(($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
                  1'($urandom), 2'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule